// File: doc/BRIEF.md
# Dual LED Channel Fault Supervisor

This block supervises two constant-current LED channels that share one step-up/step-down converter. It decides, on every cycle of the converter's switching clock, whether each channel may sink current. It also watches per-channel comparator flags for open and shorted LED strings. A channel's current follows the PWM dimming input directly, so the light duty equals the PWM duty.

A fault is only believed when the converter's output-voltage window agrees with it. An open string is a channel pin reading low while the output sits above the open threshold, and it takes that channel out on the next clock edge. A shorted string is a channel pin reading high while the output sits below the short threshold. It must persist for a programmable number of PWM-high switching cycles before that channel is taken out. Only the faulty channel goes dark, and the other keeps running. The latches are released only by dropping the chip enable or by an undervoltage trip.

Each channel runs its own state machine. The states are `CH_OFF` (not enabled), `CH_RUN` (healthy), `CH_SHORT_WAIT` (short debounce counting), `CH_OPEN_HIT` (open latched) and `CH_SHORT_HIT` (short latched). The transitions are named as follows:
- power-up: `CH_OFF` to `CH_RUN` when enabled.
- open-trip: `CH_RUN` or `CH_SHORT_WAIT` to `CH_OPEN_HIT`.
- short-arm: `CH_RUN` to `CH_SHORT_WAIT`.
- short-clear: `CH_SHORT_WAIT` to `CH_RUN`.
- short-trip: `CH_RUN` or `CH_SHORT_WAIT` to `CH_SHORT_HIT`.
- power-down: any state to `CH_OFF` when not enabled.

Top module: `led_pair_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, both latches of both channels read 0, `fault_n` reads 1 and `ch_drive` reads 0. Before the first enabling edge, every channel is in `CH_OFF`.
- R2: A channel is enabled when `chip_en` is 1 and `uvlo_trip` is 0. For channel 1 (bit 1), `one_ch_mode` must also be 0. Channel 0 (bit 0) ignores `one_ch_mode`. An enabled channel leaves `CH_OFF` on the next clock edge.
- R3: For an enabled, unlatched channel, the bit of `ch_drive` is 1 exactly when `pwm_in` is 1, in the same cycle with no register delay.
- R4: With the channel running, `pin_low` of that channel at 1 and `out_above_open` at 1 at a clock edge set that channel's bit of `open_latch` on that edge. The channel's drive then stays 0. The other channel is unaffected.
- R5: `pin_high` of a channel at 1, with `out_below_short` at 1 and `pwm_in` at 1, is a qualifying cycle. After SHORT_LIMIT consecutive qualifying edges, that channel's bit of `short_latch` is set, and not one edge earlier. SHORT_LIMIT defaults to 32770.
- R6: An edge with `pwm_in` at 1 and the short condition false, before the limit is reached, returns the count to zero. A later short then needs the full SHORT_LIMIT qualifying edges again.
- R7: Edges with `pwm_in` at 0 neither advance nor clear the short count.
- R8: `fault_n` is 0 exactly when any bit of `open_latch` or `short_latch` is 1.
- R9: A latched channel stays latched after its fault condition is removed. The latch clears on the first edge with `chip_en` at 0 or `uvlo_trip` at 1.
- R10: A channel that is not enabled never sets a latch, and its drive is 0, whatever its comparator flags show.
- R11: A pin flag without its window flag causes no fault: `pin_low` needs `out_above_open`, and `pin_high` needs `out_below_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter switching clock, which also times the short debounce |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| chip_en | input | 1 | Chip enable; 0 turns both channels off and clears their latches |
| uvlo_trip | input | 1 | Undervoltage trip; 1 turns both channels off and clears their latches |
| one_ch_mode | input | 1 | 1 runs channel 0 only; 0 runs both channels |
| pwm_in | input | 1 | PWM dimming input |
| pin_low | input | NUM_CH | Per-channel comparator flag: LED pin below the low threshold |
| pin_high | input | NUM_CH | Per-channel comparator flag: LED pin above the high threshold |
| out_above_open | input | 1 | Converter output is above the open-qualify threshold |
| out_below_short | input | 1 | Converter output is below the short-qualify threshold |
| ch_drive | output | NUM_CH | Per-channel current-sink enable |
| open_latch | output | NUM_CH | Per-channel latched open fault |
| short_latch | output | NUM_CH | Per-channel latched short fault |
| fault_n | output | 1 | Active-low open/short fault summary |

## Verification
The assertions assume that every input is synchronous to the switching clock and changes at most once per cycle. They also assume that `pin_low` and `pin_high` of one channel are never both 1, as is true of a real pin voltage. The bench drives every input a short time after the rising edge and never raises both pin flags of a channel together. The bench shortens SHORT_LIMIT so that the debounce boundary can be reached exactly. It then counts qualifying edges one by one around that boundary.

// File: rtl/led_guard_pkg.sv
package led_guard_pkg;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_RUN,
        CH_SHORT_WAIT,
        CH_OPEN_HIT,
        CH_SHORT_HIT
    } chan_state_t;

endpackage

// File: rtl/led_mode_decode.sv
module led_mode_decode #(
    parameter int NUM_CH = 2
) (
    input  logic              chip_en,
    input  logic              uvlo_trip,
    input  logic              one_ch_mode,
    output logic [NUM_CH-1:0] ch_enable
);

    logic powered;
    assign powered = chip_en && !uvlo_trip;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_en
        if (g == 0) begin : g_first
            // the first channel runs in both modes
            assign ch_enable[g] = powered;
        end else begin : g_rest
            assign ch_enable[g] = powered && !one_ch_mode;
        end
    end

endmodule

// File: rtl/led_short_timer.sv
module led_short_timer #(
    parameter int SHORT_LIMIT = 32770
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);

    localparam int CNT_W = $clog2(SHORT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SHORT_LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // true on the qualifying edge that completes the debounce window
    assign done = inc && (cnt == LAST);

endmodule

// File: rtl/led_chan_fsm.sv
module led_chan_fsm
    import led_guard_pkg::*;
#(
    parameter int SHORT_LIMIT = 32770
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm,
    input  logic open_cond,
    input  logic short_cond,
    output logic drive,
    output logic open_hit,
    output logic short_hit
);

    chan_state_t state, state_nx;
    logic        live;
    logic        t_inc;
    logic        t_clr;
    logic        t_done;

    assign live  = (state == CH_RUN) || (state == CH_SHORT_WAIT);
    assign t_inc = enable && live && pwm && short_cond && !open_cond;
    assign t_clr = !enable || !live || open_cond || (pwm && !short_cond);

    led_short_timer #(.SHORT_LIMIT(SHORT_LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .inc   (t_inc),
        .done  (t_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = CH_OFF;
        end else begin
            unique case (state)
                CH_OFF: begin
                    state_nx = CH_RUN;
                end
                CH_RUN: begin
                    if (open_cond) begin
                        state_nx = CH_OPEN_HIT;
                    end else if (pwm && short_cond) begin
                        state_nx = t_done ? CH_SHORT_HIT : CH_SHORT_WAIT;
                    end
                end
                CH_SHORT_WAIT: begin
                    if (open_cond) begin
                        state_nx = CH_OPEN_HIT;
                    end else if (pwm && short_cond && t_done) begin
                        state_nx = CH_SHORT_HIT;
                    end else if (pwm && !short_cond) begin
                        state_nx = CH_RUN;
                    end
                end
                CH_OPEN_HIT: begin
                    state_nx = CH_OPEN_HIT;
                end
                CH_SHORT_HIT: begin
                    state_nx = CH_SHORT_HIT;
                end
                default: begin
                    state_nx = CH_OFF;
                end
            endcase
        end
    end

    always_comb begin
        drive     = enable && pwm && live;
        open_hit  = (state == CH_OPEN_HIT);
        short_hit = (state == CH_SHORT_HIT);
    end

endmodule

// File: rtl/led_pair_guard.sv
module led_pair_guard #(
    parameter int NUM_CH      = 2,
    parameter int SHORT_LIMIT = 32770
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              uvlo_trip,
    input  logic              one_ch_mode,
    input  logic              pwm_in,
    input  logic [NUM_CH-1:0] pin_low,
    input  logic [NUM_CH-1:0] pin_high,
    input  logic              out_above_open,
    input  logic              out_below_short,
    output logic [NUM_CH-1:0] ch_drive,
    output logic [NUM_CH-1:0] open_latch,
    output logic [NUM_CH-1:0] short_latch,
    output logic              fault_n
);

    logic [NUM_CH-1:0] ch_enable;

    led_mode_decode #(.NUM_CH(NUM_CH)) u_mode (
        .chip_en     (chip_en),
        .uvlo_trip   (uvlo_trip),
        .one_ch_mode (one_ch_mode),
        .ch_enable   (ch_enable)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic open_c;
        logic short_c;
        assign open_c  = pin_low[g] && out_above_open;
        assign short_c = pin_high[g] && out_below_short;

        led_chan_fsm #(.SHORT_LIMIT(SHORT_LIMIT)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (ch_enable[g]),
            .pwm        (pwm_in),
            .open_cond  (open_c),
            .short_cond (short_c),
            .drive      (ch_drive[g]),
            .open_hit   (open_latch[g]),
            .short_hit  (short_latch[g])
        );
    end

    assign fault_n = ~(|{open_latch, short_latch});

endmodule

// File: rtl/led_pair_guard_chk.sv
module led_pair_guard_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              uvlo_trip,
    input logic              one_ch_mode,
    input logic              pwm_in,
    input logic [NUM_CH-1:0] pin_low,
    input logic [NUM_CH-1:0] pin_high,
    input logic              out_above_open,
    input logic              out_below_short,
    input logic [NUM_CH-1:0] ch_drive,
    input logic [NUM_CH-1:0] open_latch,
    input logic [NUM_CH-1:0] short_latch,
    input logic              fault_n
);

    // R8: any latched channel pulls the summary low
    assert_fault_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|{open_latch, short_latch}) |-> !fault_n);

    // R9: dropping the enable clears every latch on the next edge
    assert_enable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en || uvlo_trip) |=> !(|{open_latch, short_latch}));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4: a latched channel never sinks current
        assert_latched_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (open_latch[g] || short_latch[g]) |-> !ch_drive[g]);

        // R4: a running channel with a qualified open latches on the next edge
        assert_open_trips_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_drive[g] && pin_low[g] && out_above_open && !pin_high[g])
            |=> open_latch[g]);

        // R5: a short latch only rises after a qualifying PWM-high cycle
        assert_short_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(short_latch[g]) |-> ($past(pwm_in) && $past(pin_high[g])
                                       && $past(out_below_short)));

        if (g == 0) begin : g_first
            // R9: a latch persists while the chip stays powered
            assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (open_latch[g] && chip_en && !uvlo_trip) |=> open_latch[g]);
        end else begin : g_rest
            // R10: a channel switched off by the mode pin is dark and fault-free
            assert_disabled_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
                one_ch_mode |-> !ch_drive[g]);
            assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
                one_ch_mode |=> !(open_latch[g] || short_latch[g]));
        end
    end

endmodule

bind led_pair_guard led_pair_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .chip_en         (chip_en),
    .uvlo_trip       (uvlo_trip),
    .one_ch_mode     (one_ch_mode),
    .pwm_in          (pwm_in),
    .pin_low         (pin_low),
    .pin_high        (pin_high),
    .out_above_open  (out_above_open),
    .out_below_short (out_below_short),
    .ch_drive        (ch_drive),
    .open_latch      (open_latch),
    .short_latch     (short_latch),
    .fault_n         (fault_n)
);

// File: tb/led_pair_guard_bench.sv
module led_pair_guard_bench;

    localparam int LIM = 12;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       uvlo_trip = 1'b0;
    logic       one_ch_mode = 1'b0;
    logic       pwm_in = 1'b0;
    logic [1:0] pin_low = 2'b00;
    logic [1:0] pin_high = 2'b00;
    logic       out_above_open = 1'b0;
    logic       out_below_short = 1'b0;
    logic [1:0] ch_drive;
    logic [1:0] open_latch;
    logic [1:0] short_latch;
    logic       fault_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    led_pair_guard #(.NUM_CH(2), .SHORT_LIMIT(LIM)) u_led_pair_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .chip_en         (chip_en),
        .uvlo_trip       (uvlo_trip),
        .one_ch_mode     (one_ch_mode),
        .pwm_in          (pwm_in),
        .pin_low         (pin_low),
        .pin_high        (pin_high),
        .out_above_open  (out_above_open),
        .out_below_short (out_below_short),
        .ch_drive        (ch_drive),
        .open_latch      (open_latch),
        .short_latch     (short_latch),
        .fault_n         (fault_n)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2ns;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        pin_low = 2'b00;
        pin_high = 2'b00;
        out_above_open = 1'b0;
        out_below_short = 1'b0;
        one_ch_mode = 1'b0;
        uvlo_trip = 1'b0;
    endtask

    task automatic restart();
        quiet_inputs();
        chip_en = 1'b0;
        step(1);
        chip_en = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 drive in reset", ch_drive, 0);
        chk("R1 fault_n in reset", fault_n, 1);
        rst_n = 1'b1;
        pwm_in = 1'b1;
        step(1);
        chk("R1 open after reset", open_latch, 0);
        chk("R1 short after reset", short_latch, 0);
        chk("R1 drive before enable", ch_drive, 0);
    endtask

    task automatic t_mode();
        restart();
        pwm_in = 1'b1;
        #1ns;
        chk("R2 both channels run", ch_drive, 3);
        one_ch_mode = 1'b1;
        #1ns;
        chk("R2 one-channel mode", ch_drive, 1);
        one_ch_mode = 1'b0;
        step(1);
        chk("R2 channel 1 back after one edge", ch_drive, 3);
    endtask

    task automatic t_pwm();
        restart();
        for (int i = 0; i < 6; i++) begin
            pwm_in = i[0];
            #1ns;
            chk("R3 drive follows pwm", ch_drive, i[0] ? 3 : 0);
            step(1);
        end
    endtask

    task automatic t_open();
        restart();
        pwm_in = 1'b1;
        pin_low = 2'b10;
        out_above_open = 1'b1;
        step(1);
        chk("R4 open latched ch1", open_latch, 2);
        chk("R4 ch1 dark, ch0 on", ch_drive, 1);
        chk("R8 fault_n low", fault_n, 0);
    endtask

    task automatic t_short_count();
        restart();
        pwm_in = 1'b1;
        pin_high = 2'b01;
        out_below_short = 1'b1;
        step(LIM - 1);
        chk("R5 not latched one edge early", short_latch, 0);
        step(1);
        chk("R5 latched at limit", short_latch, 1);
        chk("R5 ch0 dark, ch1 on", ch_drive, 2);
        chk("R8 fault_n low on short", fault_n, 0);
    endtask

    task automatic t_short_restart();
        restart();
        pwm_in = 1'b1;
        out_below_short = 1'b1;
        pin_high = 2'b01;
        step(LIM - 2);
        pin_high = 2'b00;
        step(1);
        pin_high = 2'b01;
        step(LIM - 1);
        chk("R6 count restarted", short_latch, 0);
        step(1);
        chk("R6 full window after restart", short_latch, 1);
    endtask

    task automatic t_short_hold();
        restart();
        pwm_in = 1'b1;
        out_below_short = 1'b1;
        pin_high = 2'b10;
        step(5);
        pwm_in = 1'b0;
        pin_high = 2'b00;
        step(20);
        chk("R7 no latch while pwm low", short_latch, 0);
        pwm_in = 1'b1;
        pin_high = 2'b10;
        step(LIM - 6);
        chk("R7 held count not yet done", short_latch, 0);
        step(1);
        chk("R7 held count completes", short_latch, 2);
    endtask

    task automatic t_qualify();
        restart();
        pwm_in = 1'b1;
        pin_low = 2'b11;
        step(4);
        chk("R11 pin low without window", open_latch, 0);
        pin_low = 2'b00;
        pin_high = 2'b11;
        step(LIM + 3);
        chk("R11 pin high without window", short_latch, 0);
        chk("R11 fault_n stays high", fault_n, 1);
    endtask

    task automatic t_clear();
        restart();
        pwm_in = 1'b1;
        pin_low = 2'b01;
        out_above_open = 1'b1;
        step(1);
        pin_low = 2'b00;
        out_above_open = 1'b0;
        step(3);
        chk("R9 latch survives removal", open_latch, 1);
        uvlo_trip = 1'b1;
        step(1);
        chk("R9 undervoltage clears", open_latch, 0);
        chk("R9 fault_n released", fault_n, 1);
        uvlo_trip = 1'b0;
        step(1);
        chk("R9 channels run again", ch_drive, 3);
        pin_high = 2'b10;
        out_below_short = 1'b1;
        step(LIM);
        pin_high = 2'b00;
        chip_en = 1'b0;
        step(1);
        chk("R9 enable low clears short", short_latch, 0);
        chip_en = 1'b1;
    endtask

    task automatic t_disabled();
        restart();
        one_ch_mode = 1'b1;
        pwm_in = 1'b1;
        pin_low = 2'b10;
        out_above_open = 1'b1;
        step(3);
        chk("R10 no open on disabled ch", open_latch, 0);
        chk("R10 disabled drive dark", ch_drive, 1);
        pin_low = 2'b00;
        out_above_open = 1'b0;
        pin_high = 2'b10;
        out_below_short = 1'b1;
        step(LIM + 2);
        chk("R10 no short on disabled ch", short_latch, 0);
        pin_high = 2'b00;
        out_below_short = 1'b0;
        one_ch_mode = 1'b0;
        step(2);
        chk("R10 counter zero after re-enable", short_latch, 0);
        pin_high = 2'b10;
        out_below_short = 1'b1;
        step(LIM - 1);
        chk("R10 fresh window after re-enable", short_latch, 0);
        step(1);
        chk("R10 latches after full window", short_latch, 2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_mode();
        t_pwm();
        t_open();
        t_short_count();
        t_short_restart();
        t_short_hold();
        t_qualify();
        t_clear();
        t_disabled();
        summary();
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
        end
    end

endmodule